// File: doc/BRIEF.md
# Table-Driven Pixel Reorder Sequencer

This block sits between a parallel camera frame-grabber port and a processor's data memory. Every pixel that arrives is written to a memory address taken from a small user-loaded lookup table. The table entry used is chosen by the pixel's arrival position within the current frame. The result is that pixels land in whatever layout the later slope computation wants, not in raster order. Each table entry also holds a small increment: the number of slopes that become computable once that pixel is stored. A running total of these increments is presented as a ready-slope count, so the processor can start computing while readout is still under way.

The camera's frame sync is the time base. It clears the position index, the ready-slope count and the overrun flag. The table is written, and its length set, through a load port. Loads are accepted only outside a frame in progress. Once the configured number of pixels has been stored, any further pixels are discarded and flagged as overrun until the next sync.

Top module: `pix_reorder_seq`

## Requirements
- R1: After reset, `mem_we`, `slope_rdy` and `overrun` are 0. Pixels that arrive before the first frame sync produce no write and do not raise `overrun`.
- R2: A pixel accepted as the n-th of a frame (n counted from 0) appears one clock after its input cycle as `mem_we`=1, with `mem_addr` equal to the address in table entry n and `mem_data` equal to the pixel value.
- R3: A `pix_fsync` cycle restarts the index at 0. This also holds in the middle of a frame. A pixel that is valid in the same cycle as the sync is pixel 0 of the new frame.
- R4: `slope_rdy` is cleared by a sync. It grows by the increment field of table entry n in the same clock that pixel n's write appears, and the increment of a pixel carried in the sync cycle is included.
- R5: Once the configured length of pixels has been stored, further valid pixels produce no write. `overrun` reads 1 from the clock after the first such pixel, and a later sync clears it.
- R6: Table-entry loads (`tbl_we`) and length loads (`len_we`) made while a frame is in progress are ignored. A frame is in progress once a sync has been seen and fewer than the configured length of pixels have been stored.
- R7: Loads made before the first sync or after a frame has completed take effect for the next frame.
- R8: With a configured length of 0, a sync starts no frame. Every valid pixel after it is dropped and raises `overrun`.
- R9: Cycles with `pix_vld`=0 do not advance the index. Gaps inside a frame leave the mapping unchanged.
- R10: A length load larger than the table depth is clamped to the depth. After reset the length equals the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_vld | input | 1 | Pixel present this cycle |
| pix_fsync | input | 1 | Frame sync, restarts the sequence |
| pix_data | input | PIX_W | Pixel value |
| tbl_we | input | 1 | Load one table entry |
| tbl_idx | input | IDX_W | Entry number being loaded |
| tbl_addr | input | ADDR_W | Destination address for that entry |
| tbl_inc | input | INC_W | Slopes made ready by that entry's pixel |
| len_we | input | 1 | Load frame length |
| len_val | input | LEN_W | Number of pixels per frame (clamped to DEPTH) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | PIX_W | Memory write data |
| slope_rdy | output | CNT_W | Slopes computable so far this frame |
| overrun | output | 1 | Pixel(s) dropped beyond table length |

## Verification
Each of the block's results is registered once after the table lookup. The write strobe, address and data for a pixel are due one clock after its input cycle, and the updated ready count and overrun flag become visible at that same clock. A load takes effect at its clock edge and shows only through the addresses of the next frame. The bench drives every input on the falling edge. It samples all outputs on the next falling edge, which is exactly one rising edge after the stimulus, and compares them with a model that walks the index, the count and the flag from the requirements.

// File: rtl/pix_reorder_pkg.sv
package pix_reorder_pkg;
   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_RUN  = 2'd1,
      FR_DONE = 2'd2
   } frame_state_e;
endpackage

// File: rtl/pix_lut_bank.sv
module pix_lut_bank #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 10,
   parameter int INC_W  = 3,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [INC_W-1:0]  wr_inc,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [INC_W-1:0]  rd_inc
);
   logic [ADDR_W-1:0] addr_tab [DEPTH];
   logic [INC_W-1:0]  inc_tab  [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [ADDR_W-1:0] ent_addr;
      logic [INC_W-1:0]  ent_inc;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_addr <= '0;
            ent_inc  <= '0;
         end else if (wr_en && (int'(wr_idx) == g)) begin
            ent_addr <= wr_addr;
            ent_inc  <= wr_inc;
         end
      end
      assign addr_tab[g] = ent_addr;
      assign inc_tab[g]  = ent_inc;
   end

   always_comb begin
      rd_addr = '0;
      rd_inc  = '0;
      if (int'(rd_idx) < DEPTH) begin
         rd_addr = addr_tab[rd_idx];
         rd_inc  = inc_tab[rd_idx];
      end
   end
endmodule

// File: rtl/pix_frame_ctl.sv
module pix_frame_ctl
   import pix_reorder_pkg::*;
#(
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int LEN_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_vld,
   input  logic             pix_fsync,
   input  logic             len_we,
   input  logic [LEN_W-1:0] len_val,
   output logic             cfg_ok,
   output logic [IDX_W-1:0] rd_idx,
   output logic             accept,
   output logic             ovf_set
);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DEPTH);

   frame_state_e     st_q, st_eff;
   logic [LEN_W-1:0] idx_q, idx_eff, idx_nxt;
   logic [LEN_W-1:0] len_q;

   always_comb begin
      st_eff  = st_q;
      idx_eff = idx_q;
      if (pix_fsync) begin
         idx_eff = '0;
         st_eff  = (len_q == '0) ? FR_DONE : FR_RUN;
      end
      idx_nxt = idx_eff + LEN_W'(1);
   end

   assign accept  = pix_vld && (st_eff == FR_RUN);
   assign ovf_set = pix_vld && (st_eff == FR_DONE);
   assign rd_idx  = idx_eff[IDX_W-1:0];
   assign cfg_ok  = (st_q != FR_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= FR_IDLE;
         idx_q <= '0;
      end else if (accept) begin
         idx_q <= idx_nxt;
         st_q  <= (idx_nxt == len_q) ? FR_DONE : FR_RUN;
      end else if (pix_fsync) begin
         idx_q <= '0;
         st_q  <= st_eff;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         len_q <= LEN_MAX;
      else if (len_we && cfg_ok)
         len_q <= (len_val > LEN_MAX) ? LEN_MAX : len_val;
   end
endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage #(
   parameter int PIX_W  = 12,
   parameter int ADDR_W = 10,
   parameter int INC_W  = 3,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              frame_clr,
   input  logic              ovf_set,
   input  logic [ADDR_W-1:0] lut_addr,
   input  logic [INC_W-1:0]  lut_inc,
   input  logic [PIX_W-1:0]  pix_data,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [PIX_W-1:0]  mem_data,
   output logic [CNT_W-1:0]  slope_rdy,
   output logic              overrun
);
   logic [CNT_W-1:0] cnt_base;

   assign cnt_base = frame_clr ? '0 : slope_rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_data  <= '0;
         slope_rdy <= '0;
         overrun   <= 1'b0;
      end else begin
         mem_we    <= accept;
         slope_rdy <= cnt_base + (accept ? CNT_W'(lut_inc) : '0);
         overrun   <= (frame_clr ? 1'b0 : overrun) | ovf_set;
         if (accept) begin
            mem_addr <= lut_addr;
            mem_data <= pix_data;
         end
      end
   end
endmodule

// File: rtl/pix_reorder_seq.sv
module pix_reorder_seq #(
   parameter int PIX_W  = 12,
   parameter int ADDR_W = 10,
   parameter int DEPTH  = 16,
   parameter int INC_W  = 3,
   parameter int CNT_W  = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int LEN_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_vld,
   input  logic              pix_fsync,
   input  logic [PIX_W-1:0]  pix_data,
   input  logic              tbl_we,
   input  logic [IDX_W-1:0]  tbl_idx,
   input  logic [ADDR_W-1:0] tbl_addr,
   input  logic [INC_W-1:0]  tbl_inc,
   input  logic              len_we,
   input  logic [LEN_W-1:0]  len_val,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [PIX_W-1:0]  mem_data,
   output logic [CNT_W-1:0]  slope_rdy,
   output logic              overrun
);
   localparam int MAX_SUM = DEPTH * ((1 << INC_W) - 1);

   initial begin : p_elab
      if (DEPTH < 2)                       $error("DEPTH must be at least 2");
      if (PIX_W < 1 || ADDR_W < 1)         $error("PIX_W and ADDR_W must be positive");
      if (INC_W < 1)                       $error("INC_W must be positive");
      if ($clog2(MAX_SUM + 1) > CNT_W)     $error("CNT_W too narrow for a full frame");
   end

   logic              cfg_ok, accept, ovf_set;
   logic [IDX_W-1:0]  rd_idx;
   logic [ADDR_W-1:0] lut_addr;
   logic [INC_W-1:0]  lut_inc;

   pix_frame_ctl #(.DEPTH(DEPTH)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .pix_vld(pix_vld), .pix_fsync(pix_fsync),
      .len_we(len_we), .len_val(len_val),
      .cfg_ok(cfg_ok), .rd_idx(rd_idx),
      .accept(accept), .ovf_set(ovf_set)
   );

   pix_lut_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .INC_W(INC_W)) u_lut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_we && cfg_ok), .wr_idx(tbl_idx),
      .wr_addr(tbl_addr), .wr_inc(tbl_inc),
      .rd_idx(rd_idx), .rd_addr(lut_addr), .rd_inc(lut_inc)
   );

   pix_out_stage #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .INC_W(INC_W), .CNT_W(CNT_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .accept(accept), .frame_clr(pix_fsync), .ovf_set(ovf_set),
      .lut_addr(lut_addr), .lut_inc(lut_inc), .pix_data(pix_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
      .slope_rdy(slope_rdy), .overrun(overrun)
   );
endmodule

// File: rtl/pix_reorder_chk.sv
module pix_reorder_chk #(
   parameter int PIX_W = 12,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_vld,
   input logic             pix_fsync,
   input logic [PIX_W-1:0] pix_data,
   input logic             mem_we,
   input logic [PIX_W-1:0] mem_data,
   input logic [CNT_W-1:0] slope_rdy,
   input logic             overrun
);
   a_r2_write_follows_pixel: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(pix_vld) && mem_data == $past(pix_data)));

   a_r5_no_write_in_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> !mem_we);

   a_r4_count_grows_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pix_fsync) |-> (slope_rdy >= $past(slope_rdy)));

   a_r4_count_moves_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(pix_fsync) && !mem_we) |-> $stable(slope_rdy));

   a_r3_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pix_fsync && !pix_vld) |-> (!overrun && slope_rdy == '0 && !mem_we));
endmodule

bind pix_reorder_seq pix_reorder_chk #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_fsync(pix_fsync),
   .pix_data(pix_data), .mem_we(mem_we), .mem_data(mem_data),
   .slope_rdy(slope_rdy), .overrun(overrun)
);

// File: tb/pix_reorder_seq_bench.sv
module pix_reorder_seq_bench;
   localparam int PIX_W = 8, ADDR_W = 6, DEPTH = 8, INC_W = 2, CNT_W = 6;
   localparam int IDX_W = $clog2(DEPTH), LEN_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              pix_vld = 0, pix_fsync = 0, tbl_we = 0, len_we = 0;
   logic [PIX_W-1:0]  pix_data = '0;
   logic [IDX_W-1:0]  tbl_idx = '0;
   logic [ADDR_W-1:0] tbl_addr = '0;
   logic [INC_W-1:0]  tbl_inc = '0;
   logic [LEN_W-1:0]  len_val = '0;
   logic              mem_we, overrun;
   logic [ADDR_W-1:0] mem_addr;
   logic [PIX_W-1:0]  mem_data;
   logic [CNT_W-1:0]  slope_rdy;

   pix_reorder_seq #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH),
                     .INC_W(INC_W), .CNT_W(CNT_W)) u_pix_reorder_seq (
      .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_fsync(pix_fsync),
      .pix_data(pix_data), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
      .tbl_addr(tbl_addr), .tbl_inc(tbl_inc), .len_we(len_we),
      .len_val(len_val), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_data(mem_data), .slope_rdy(slope_rdy), .overrun(overrun)
   );

   int total = 0, bad = 0;
   bit finished = 0;
   int m_a [DEPTH];
   int m_i [DEPTH];
   int m_len = DEPTH, m_idx = 0, m_cnt = 0;
   bit m_run = 0, m_done = 0, m_ovf = 0;

   task automatic chk(string tag, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   task automatic step(string tag, bit v, bit fs, int d);
      bit e_we = 0;
      int e_addr = 0;
      pix_vld = v; pix_fsync = fs; pix_data = PIX_W'(d);
      if (fs) begin
         m_idx = 0; m_cnt = 0; m_ovf = 0;
         m_run = (m_len > 0); m_done = (m_len == 0);
      end
      if (v) begin
         if (m_run) begin
            e_we = 1; e_addr = m_a[m_idx];
            m_cnt += m_i[m_idx]; m_idx++;
            if (m_idx == m_len) begin m_run = 0; m_done = 1; end
         end else if (m_done) m_ovf = 1;
      end
      @(negedge clk);
      pix_vld = 0; pix_fsync = 0;
      chk({tag, " write strobe"}, int'(mem_we), int'(e_we));
      if (e_we) begin
         chk({tag, " address"}, int'(mem_addr), e_addr);
         chk({tag, " data"}, int'(mem_data), d & ((1 << PIX_W) - 1));
      end
      chk({tag, " ready slopes"}, int'(slope_rdy), m_cnt);
      chk({tag, " overrun"}, int'(overrun), int'(m_ovf));
   endtask

   task automatic load_entry(int i, int a, int inc);
      tbl_we = 1; tbl_idx = IDX_W'(i); tbl_addr = ADDR_W'(a); tbl_inc = INC_W'(inc);
      if (!m_run) begin m_a[i] = a % (1 << ADDR_W); m_i[i] = inc % (1 << INC_W); end
      @(negedge clk);
      tbl_we = 0;
   endtask

   task automatic load_len(int n);
      len_we = 1; len_val = LEN_W'(n);
      if (!m_run) m_len = (n > DEPTH) ? DEPTH : n;
      @(negedge clk);
      len_we = 0;
   endtask

   task automatic frame(string tag, int n, int seed);
      for (int k = 0; k < n; k++) step(tag, 1, k == 0, k * 37 + seed);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) begin m_a[i] = 0; m_i[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state and pixels before any sync
      chk("R1 reset write strobe", int'(mem_we), 0);
      chk("R1 reset ready slopes", int'(slope_rdy), 0);
      chk("R1 reset overrun", int'(overrun), 0);
      for (int k = 0; k < 3; k++) step("R1 pre-sync", 1, 0, k + 5);
      // R7 load before first frame
      for (int i = 0; i < DEPTH; i++) load_entry(i, (i * 5 + 3) % 64, i % 4);
      // R2 R3 R4 full frame, sync together with first pixel; R5 extra pixels
      frame("R2", DEPTH, 1);
      step("R5 extra", 1, 0, 200);
      step("R5 extra", 1, 0, 201);
      step("R5 idle", 0, 0, 0);
      // R9 gaps inside a frame, sync alone
      step("R3 sync only", 0, 1, 0);
      for (int k = 0; k < 2 * DEPTH; k++) step("R9", k % 3 != 1, 0, k + 60);
      // R6 loads during a frame are ignored
      step("R6", 1, 1, 11);
      step("R6", 1, 0, 12);
      load_entry(2, 63, 3);
      load_len(3);
      for (int k = 2; k < DEPTH + 1; k++) step("R6", 1, 0, k + 90);
      // R7 reload after frame: new map and shorter length
      for (int i = 0; i < DEPTH; i++) load_entry(i, 60 - i * 3, (i + 1) % 4);
      load_len(5);
      frame("R7", 7, 7);
      // R3 restart in the middle of a frame
      frame("R3 first", 3, 40);
      frame("R3 restarted", 5, 41);
      // R8 zero length
      load_len(0);
      step("R8 sync", 0, 1, 0);
      step("R8 pixel", 1, 0, 3);
      step("R8 sync with pixel", 1, 1, 4);
      // R10 clamp
      load_len(13);
      frame("R10", DEPTH + 1, 9);
      // R4 sweep of all lengths and maps
      for (int n = 1; n <= DEPTH; n++) begin
         for (int i = 0; i < DEPTH; i++) load_entry(i, (i * 7 + n) % 64, (i + n) % 4);
         load_len(n);
         frame("R4 sweep", n + 2, n);
      end
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule